// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds one 32-bit configuration word for each GPIO pin of a controller. Software reaches the words over a simple register bus. Each word packs five fields:

- an output data bit;
- a three-bit mode that sets both the pin direction and the interrupt trigger;
- a peripheral-routing bit;
- a configuration-done flag;
- a three-bit interrupt-group number.

From these fields the block drives each pad's output value and output enable. A pin is either a GPIO pin or is handed over to a peripheral, which then drives the pad directly. A separate interrupt detector uses the exported mode and group of each pin.

Reads return the stored fields. For a pin that is not in output mode, the data bit returns the pad level, passed through a two-flop synchroniser. A pin does not drive its pad until its configuration-done flag has been set. Software may write a word with the flag clear and then write it again with the flag set, and the bank takes both writes in order.

Each per-pin slice computes one of four pin states from its stored word:

- PIN_HIZ: done flag clear.
- PIN_PERIPH: done flag set and peripheral bit set.
- PIN_GPIO_OUT: done flag set, peripheral bit clear, mode 1.
- PIN_GPIO_IN: done flag set, peripheral bit clear, any other mode.

The bus responder has two states:

- BUS_IDLE moves to BUS_RESP on a read request.
- BUS_RESP stays in BUS_RESP on a further read request and returns to BUS_IDLE otherwise.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, every word holds mode 7, peripheral bit 0, done flag 0 and group 0. All pads are undriven, `irq_mode` reads 7 for every pin and `irq_group` reads 0.
- R2: Pin n's word sits at byte address 4*n, and address bits 1:0 are ignored. A write at or above 4*NUM_PINS changes nothing, and a read there returns zero.
- R3: The word layout is:
  - bit 0: data;
  - bits 3:1: mode;
  - bit 5: peripheral select;
  - bit 9: configuration done;
  - bits 18:16: interrupt group.

  All other bits read as zero, and writes to them are ignored.
- R4: While a pin's done flag is 0, its `pad_oe` and `pad_out` are 0, whatever the mode, data and peripheral bits hold.
- R5: With done 1, peripheral 0 and mode 1, `pad_oe` is 1 and `pad_out` equals the stored data bit, from the cycle after the write.
- R6: With done 1, peripheral 0 and any mode other than 1 (0, 2, 3, 4, 5, 6 or 7), `pad_oe` is 0.
- R7: With done 1 and peripheral 1, `periph_sel` is 1, and `pad_out` and `pad_oe` follow that pin's `periph_out` and `periph_oe` inputs combinationally.
- R8: In mode 1 a read returns the stored data bit in bit 0. In every other mode, bit 0 returns the synchronised pad level. A read sampled at the second rising edge after `pad_in` changes still returns the old level, and a read sampled at the third edge returns the new level.
- R9: `irq_mode` carries each pin's stored mode, with the reserved value 0 reported as 7. `irq_group` carries each pin's stored group.
- R10: A write with the done flag clear followed by a write of the same word with the flag set are both applied. After the first, the read-back shows bit 9 at 0 and the pad is undriven. After the second, the pad is driven.
- R11: `bus_rvalid` is 1 exactly in the cycle after each accepted read, with the read word on `bus_rdata`. Otherwise `bus_rvalid` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| periph_out | input | NUM_PINS | Peripheral output values |
| periph_oe | input | NUM_PINS | Peripheral output enables |
| periph_sel | output | NUM_PINS | Pin routed to peripheral |
| irq_mode | output | 3*NUM_PINS | Effective mode per pin |
| irq_group | output | 3*NUM_PINS | Interrupt group per pin |

## Verification
The assertions check three things on every cycle:

- After any pin write, the pad enable and value follow that write: undriven while done is clear, driven in output mode, undriven in the other modes, and following the peripheral when routed to it.
- A word does not change without a write.
- The exported mode is never zero, and a read response appears exactly one cycle after each read.

The bench scenarios cover what no single-cycle property captures:

- the two-edge delay of the synchroniser;
- the value that reads return, including unused bits and addresses beyond the last pin;
- the two-step configuration sequence;
- peripheral routing while the peripheral inputs change.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    localparam int WORD_W     = 32;
    localparam int BIT_DATA   = 0;
    localparam int MODE_LO    = 1;
    localparam int BIT_PERIPH = 5;
    localparam int BIT_DONE   = 9;
    localparam int GROUP_LO   = 16;

    localparam logic [2:0] MODE_OUT    = 3'd1;
    localparam logic [2:0] MODE_IN_OFF = 3'd7;
    localparam logic [2:0] MODE_RSVD   = 3'd0;

    typedef struct packed {
        logic [2:0] grp;
        logic       done;
        logic       periph;
        logic [2:0] mode;
        logic       dbit;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{grp: 3'd0, done: 1'b0, periph: 1'b0,
                                       mode: MODE_IN_OFF, dbit: 1'b0};

    typedef enum logic [1:0] {
        PIN_HIZ,
        PIN_GPIO_IN,
        PIN_GPIO_OUT,
        PIN_PERIPH
    } pin_state_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  pin_cfg_t          wcfg,
    input  logic              pad_sync,
    input  logic              periph_out,
    input  logic              periph_oe,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              periph_sel,
    output logic [2:0]        mode_eff,
    output logic [2:0]        grp,
    output logic [WORD_W-1:0] rd_word
);
    pin_cfg_t   cfg_q;
    pin_state_e pin_state;

    // Register process: the stored word is the pin's state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= wcfg;
        end
    end

    always_comb begin
        if (!cfg_q.done) begin
            pin_state = PIN_HIZ;
        end else if (cfg_q.periph) begin
            pin_state = PIN_PERIPH;
        end else if (cfg_q.mode == MODE_OUT) begin
            pin_state = PIN_GPIO_OUT;
        end else begin
            pin_state = PIN_GPIO_IN;
        end
    end

    // Output process.
    always_comb begin
        pad_out    = 1'b0;
        pad_oe     = 1'b0;
        periph_sel = 1'b0;
        unique case (pin_state)
            PIN_HIZ: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
            end
            PIN_GPIO_IN: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
            end
            PIN_GPIO_OUT: begin
                pad_out = cfg_q.dbit;
                pad_oe  = 1'b1;
            end
            PIN_PERIPH: begin
                pad_out    = periph_out;
                pad_oe     = periph_oe;
                periph_sel = 1'b1;
            end
        endcase
    end

    assign mode_eff = (cfg_q.mode == MODE_RSVD) ? MODE_IN_OFF : cfg_q.mode;
    assign grp      = cfg_q.grp;

    always_comb begin
        rd_word = '0;
        rd_word[BIT_DATA]             = (cfg_q.mode == MODE_OUT) ? cfg_q.dbit : pad_sync;
        rd_word[MODE_LO +: 3]         = cfg_q.mode;
        rd_word[BIT_PERIPH]           = cfg_q.periph;
        rd_word[BIT_DONE]             = cfg_q.done;
        rd_word[GROUP_LO +: 3]        = cfg_q.grp;
    end

    // R4
    hiz_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wcfg.done) |=> (!pad_oe && !pad_out));

    // R5
    out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcfg.done && !wcfg.periph && wcfg.mode == MODE_OUT)
        |=> (pad_oe && pad_out == $past(wcfg.dbit)));

    // R6
    input_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcfg.done && !wcfg.periph && wcfg.mode != MODE_OUT) |=> !pad_oe);

    // R7
    periph_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcfg.done && wcfg.periph)
        |=> (periph_sel && pad_oe == periph_oe && pad_out == periph_out));

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_word[WORD_W-1:1]));

    // R9
    mode_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_eff != MODE_RSVD);
endmodule

// File: rtl/gpio_cfg_bus.sv
module gpio_cfg_bus
    import gpio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [WORD_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_req ? rd_word : '0;
        end
    end

    // Output process.
    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            BUS_RESP: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
        endcase
    end

    // R11
    resp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    input  logic [NUM_PINS-1:0]   periph_out,
    input  logic [NUM_PINS-1:0]   periph_oe,
    output logic [NUM_PINS-1:0]   periph_sel,
    output logic [3*NUM_PINS-1:0] irq_mode,
    output logic [3*NUM_PINS-1:0] irq_group
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    word_idx;
    logic                rd_req;
    logic                wr_req;
    pin_cfg_t            wcfg;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] pad_sync;
    logic [WORD_W-1:0]   words [NUM_PINS];
    logic [WORD_W-1:0]   rd_word;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign rd_req   = bus_sel && !bus_wr;
    assign wr_req   = bus_sel && bus_wr;

    assign wcfg.dbit   = bus_wdata[BIT_DATA];
    assign wcfg.mode   = bus_wdata[MODE_LO +: 3];
    assign wcfg.periph = bus_wdata[BIT_PERIPH];
    assign wcfg.done   = bus_wdata[BIT_DONE];
    assign wcfg.grp    = bus_wdata[GROUP_LO +: 3];

    wire unused_bus_bits = ^{bus_addr[1:0], bus_wdata[31:19], bus_wdata[15:10],
                             bus_wdata[8:6], bus_wdata[4]};

    gpio_sync2 #(.WIDTH(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign hit[i] = (word_idx == IDX_W'(i));

        gpio_pin_slice slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_req && hit[i]),
            .wcfg       (wcfg),
            .pad_sync   (pad_sync[i]),
            .periph_out (periph_out[i]),
            .periph_oe  (periph_oe[i]),
            .pad_out    (pad_out[i]),
            .pad_oe     (pad_oe[i]),
            .periph_sel (periph_sel[i]),
            .mode_eff   (irq_mode[3*i +: 3]),
            .grp        (irq_group[3*i +: 3]),
            .rd_word    (words[i])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (hit[i]) begin
                rd_word = rd_word | words[i];
            end
        end
    end

    gpio_cfg_bus bus_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .rd_word(rd_word),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    // R2
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= 1);
endmodule

// File: tb/gpio_cfg_bank_tb_top.sv
module gpio_cfg_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int AW         = 12;
    localparam int WD_LIMIT   = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_sel, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  pad_in, pad_out, pad_oe, periph_out, periph_oe, periph_sel;
    logic [3*N-1:0] irq_mode, irq_group;

    gpio_cfg_bank #(.NUM_PINS(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .periph_out(periph_out), .periph_oe(periph_oe),
        .periph_sel(periph_sel), .irq_mode(irq_mode), .irq_group(irq_group)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          total = 0;
    int          bad   = 0;
    int          cycles = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Caller stands at a falling edge.
    task automatic bus_write(logic [AW-1:0] addr, logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk32("R11 no response after write", {31'b0, bus_rvalid}, 32'h0);
    endtask

    task automatic bus_read(logic [AW-1:0] addr, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every read response.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk32("R11 unexpected response", bus_rdata, 32'hDEAD_0000);
            end else begin
                chk32(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; periph_out = '0; periph_oe = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk32("R1 pad_oe", {24'b0, pad_oe}, 32'h0);
        chk32("R1 irq_mode", {8'b0, irq_mode}, 32'h00FF_FFFF);
        chk32("R1 irq_group", {8'b0, irq_group}, 32'h0);
        chk32("R1 periph_sel", {24'b0, periph_sel}, 32'h0);
        bus_read(12'h000, 32'h0000_000E, "R1 reset word pin0");
        bus_read(12'h01C, 32'h0000_000E, "R1 reset word pin7");

        // R8 synchroniser delay on pin0
        pad_in[0] = 1'b1;
        @(negedge clk);
        bus_read(12'h000, 32'h0000_000E, "R8 second edge old level");
        bus_read(12'h000, 32'h0000_000F, "R8 third edge new level");

        // R5 output mode on pin2, data 1, group 5
        bus_write(12'h008, 32'h0005_0203);
        chk32("R5 oe pin2", {31'b0, pad_oe[2]}, 32'h1);
        chk32("R5 out pin2", {31'b0, pad_out[2]}, 32'h1);
        chk32("R9 mode pin2", {29'b0, irq_mode[8:6]}, 32'h1);
        chk32("R9 group pin2", {29'b0, irq_group[8:6]}, 32'h5);
        bus_read(12'h008, 32'h0005_0203, "R8 output mode returns stored bit");
        bus_write(12'h00A, 32'h0005_0202);
        chk32("R5 out pin2 cleared", {31'b0, pad_out[2]}, 32'h0);
        chk32("R5 oe pin2 kept", {31'b0, pad_oe[2]}, 32'h1);

        // R7 and R3 peripheral routing on pin3, all bits written
        periph_out[3] = 1'b1; periph_oe[3] = 1'b1;
        bus_write(12'h00C, 32'hFFFF_FFFF);
        chk32("R7 periph_sel pin3", {31'b0, periph_sel[3]}, 32'h1);
        chk32("R7 oe pin3", {31'b0, pad_oe[3]}, 32'h1);
        chk32("R7 out pin3", {31'b0, pad_out[3]}, 32'h1);
        periph_out[3] = 1'b0;
        #1;
        chk32("R7 out follows periph", {31'b0, pad_out[3]}, 32'h0);
        chk32("R9 group pin3", {29'b0, irq_group[11:9]}, 32'h7);
        @(negedge clk);
        bus_read(12'h00C, 32'h0007_022E, "R3 unused bits read zero");

        // R6 and R9 reserved mode 0 on pin4
        bus_write(12'h010, 32'h0000_0201);
        chk32("R6 mode0 oe pin4", {31'b0, pad_oe[4]}, 32'h0);
        chk32("R9 mode0 reported as 7", {29'b0, irq_mode[14:12]}, 32'h7);
        bus_read(12'h010, 32'h0000_0200, "R9 mode0 stored");

        // R6 modes 2..6 on pin5
        for (int m = 2; m <= 6; m++) begin
            bus_write(12'h014, 32'h0000_0201 | (32'(m) << 1));
            chk32("R6 input mode oe pin5", {31'b0, pad_oe[5]}, 32'h0);
            chk32("R9 mode pin5", {29'b0, irq_mode[17:15]}, 32'(m));
            bus_read(12'h014, 32'h0000_0200 | (32'(m) << 1), "R8 input mode reads pad");
        end

        // R10 two-step sequence on pin6
        bus_write(12'h018, 32'h0000_0003);
        chk32("R10 first write hiz oe", {31'b0, pad_oe[6]}, 32'h0);
        chk32("R4 done clear out low", {31'b0, pad_out[6]}, 32'h0);
        bus_read(12'h018, 32'h0000_0003, "R10 first write stored");
        bus_write(12'h018, 32'h0000_0203);
        chk32("R10 second write drives", {31'b0, pad_oe[6]}, 32'h1);
        chk32("R10 second write value", {31'b0, pad_out[6]}, 32'h1);
        bus_read(12'h018, 32'h0000_0203, "R10 second write stored");

        // R4 periph and output bits with done clear on pin7
        periph_oe[7] = 1'b1; periph_out[7] = 1'b1;
        bus_write(12'h01C, 32'h0000_0023);
        chk32("R4 done clear periph ignored", {30'b0, pad_oe[7], pad_out[7]}, 32'h0);

        // R2 out-of-range accesses
        bus_write(12'h020, 32'h0000_0203);
        bus_write(12'hFFC, 32'h0000_0203);
        chk32("R2 pads unchanged", {24'b0, pad_oe}, 32'h0000_004C);
        bus_read(12'h020, 32'h0, "R2 out of range read");
        bus_read(12'hFFC, 32'h0, "R2 top address read");
        bus_read(12'h000, 32'h0000_000F, "R2 pin0 untouched");

        @(negedge clk);
        @(negedge clk);
        chk32("R11 all reads answered", 32'(exp_q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule